// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one accepted read or write request into the sequence of byte addresses its data beats use. A request carries a start address, an 8-bit length code, a 3-bit size code and a 2-bit burst-type code. Once a request is accepted, the block presents the first beat address. Each advance strobe then moves it to the next beat. The block marks the final beat and returns to idle when that beat is advanced.

Requests that the addressing rules forbid are rejected with a one-cycle error pulse, and no burst is started. The block supports three modes. A fixed burst repeats the start address on every beat. An incrementing burst aligns an unaligned start address to the beat size after the first beat. A wrapping burst folds the address back inside a window whose size is the whole burst. A new request can be taken in the same cycle that the last beat of the current burst is advanced, so bursts can run back to back without a gap.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, beat_valid_o, beat_last_o and req_err_o are all 0.
- R2: A legal request seen while idle makes beat_valid_o 1 on the next cycle, with beat_addr_o equal to the request's start address.
- R3: While a beat is valid and beat_adv_i is 0, beat_addr_o and beat_valid_o hold their values.
- R4: Burst type 2'b00 (fixed) presents the start address on every beat, and accepts lengths 0 to 15 (1 to 16 beats).
- R5: Burst type 2'b01 (incrementing) uses the start address for beat 0. Beat i>0 uses the start address aligned down to 2^size bytes plus i*2^size. Every beat after the first is aligned to 2^size.
- R6: Burst type 2'b10 (wrapping) steps by 2^size bytes inside a window of (len+1)*2^size bytes, aligned down to that window size. The address returns to the window base after the top of the window.
- R7: A burst has len+1 beats. beat_last_o is 1 only on beat number len. When that beat is advanced with no new request, beat_valid_o is 0 on the next cycle.
- R8: req_err_o pulses for exactly one cycle, on the cycle after an illegal request is taken, and no burst starts. A request is illegal for any of these: burst type 2'b11; a wrapping length other than 1, 3, 7 or 15; a wrapping start address that is not aligned to 2^size; a fixed length above 15; or 2^size greater than DATA_BYTES.
- R9: A request raised while a burst is active, other than in the cycle the last beat is advanced, is ignored, and the current burst's addresses are unchanged.
- R10: A request raised in the same cycle as the advance of the last beat is taken. Its first beat is valid on the next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | 8 | Beats minus one |
| req_size_i | input | 3 | log2 of bytes per beat |
| req_burst_i | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| beat_adv_i | input | 1 | Advance to the next beat |
| beat_addr_o | output | ADDR_W | Current beat byte address |
| beat_valid_o | output | 1 | A beat address is presented |
| beat_last_o | output | 1 | Current beat is the final one |
| req_err_o | output | 1 | Previous request was illegal |

## Verification
Two functions can fall in the same cycle: the advance that retires the last beat of a burst, and the acceptance of a new request. The bench raises a request together with the final advance and expects the new start address on the very next cycle, with beat_valid_o never dropping. It repeats the same collision with an illegal request. In that case it expects the valid signal to fall and the error to pulse in the same cycle, which shows that the retirement and the rejection both took effect.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  localparam int unsigned LEN_W         = 8;
  localparam int unsigned SIZE_W        = 3;
  localparam int unsigned FIXED_MAX_LEN = 15;
endpackage

// File: rtl/bag_legal.sv
module bag_legal import bag_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MAX_SIZE = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        burst_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] wmask_o
);
  logic [ADDR_W-1:0] size_mask;
  logic              wrap_len_ok;

  always_comb begin
    size_mask   = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    wrap_len_ok = len_i inside {8'd1, 8'd3, 8'd7, 8'd15};
    unique case (burst_e'(burst_i))
      BT_FIXED: ok_o = 32'(len_i) <= FIXED_MAX_LEN;
      BT_INCR:  ok_o = 1'b1;
      BT_WRAP:  ok_o = wrap_len_ok && ((addr_i & size_mask) == '0);
      default:  ok_o = 1'b0;
    endcase
    if (32'(size_i) > MAX_SIZE) ok_o = 1'b0;
    // window bytes minus one; meaningful only for wrap
    wmask_o = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
  end
endmodule

// File: rtl/bag_step.sv
module bag_step import bag_pkg::*; #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        burst_i,
  input  logic [ADDR_W-1:0] wmask_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step, aligned, inc;

  always_comb begin
    step    = ADDR_W'(1) << size_i;
    aligned = addr_i & ~(step - ADDR_W'(1));
    inc     = aligned + step;
    unique case (burst_e'(burst_i))
      BT_FIXED: next_o = addr_i;
      BT_WRAP:  next_o = (addr_i & ~wmask_i) | (inc & wmask_i);
      default:  next_o = inc;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen import bag_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_len_i,
  input  logic [2:0]        req_size_i,
  input  logic [1:0]        req_burst_i,
  input  logic              beat_adv_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_valid_o,
  output logic              beat_last_o,
  output logic              req_err_o
);
  localparam int unsigned MAX_SIZE = $clog2(DATA_BYTES);

  logic [ADDR_W-1:0] addr_q, wmask_q, next_addr, wmask_d;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        burst_q;
  logic              active_q, err_q, req_ok, last, accept;
  logic [ADDR_W-1:0] size_mask;

  bag_legal #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE)) u_legal (
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .size_i (req_size_i),
    .burst_i(req_burst_i),
    .ok_o   (req_ok),
    .wmask_o(wmask_d)
  );

  bag_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .size_i (size_q),
    .burst_i(burst_q),
    .wmask_i(wmask_q),
    .next_o (next_addr)
  );

  assign last      = active_q && (cnt_q == len_q);
  // idle, or the last beat retires this cycle
  assign accept    = req_valid_i && (!active_q || (beat_adv_i && last));
  assign size_mask = (ADDR_W'(1) << size_q) - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wmask_q  <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      size_q   <= '0;
      burst_q  <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept && !req_ok;
      if (accept && req_ok) begin
        addr_q   <= req_addr_i;
        wmask_q  <= wmask_d;
        cnt_q    <= '0;
        len_q    <= req_len_i;
        size_q   <= req_size_i;
        burst_q  <= req_burst_i;
        active_q <= 1'b1;
      end else if (active_q && beat_adv_i) begin
        if (last) begin
          active_q <= 1'b0;
        end else begin
          addr_q <= next_addr;
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign beat_addr_o  = addr_q;
  assign beat_valid_o = active_q;
  assign beat_last_o  = last;
  assign req_err_o    = err_q;

  // R3
  hold_no_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_adv_i) |=> (beat_valid_o && $stable(beat_addr_o)));
  // R4
  fixed_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_adv_i && !beat_last_o && burst_q == BT_FIXED) |=> $stable(beat_addr_o));
  // R5
  aligned_after_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_adv_i && !beat_last_o && burst_q != BT_FIXED)
      |=> ((beat_addr_o & size_mask) == '0));
  // R6
  wrap_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_adv_i && !beat_last_o && burst_q == BT_WRAP)
      |=> ((beat_addr_o & ~wmask_q) == ($past(beat_addr_o) & ~wmask_q)));
  // R7
  last_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_last_o && beat_adv_i && !req_valid_i) |=> !beat_valid_o);
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (cnt_q <= len_q));
  // R8
  err_no_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> !beat_valid_o);
  // R10
  b2b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_last_o && beat_adv_i && req_valid_i && req_ok) |=> (beat_valid_o && beat_addr_o == $past(req_addr_i)));
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [1:0]  req_burst_i = '0;
  logic        beat_adv_i = 1'b0;
  logic [31:0] beat_addr_o;
  logic        beat_valid_o, beat_last_o, req_err_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen u_burst_addr_gen (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_len_i, .req_size_i,
    .req_burst_i, .beat_adv_i, .beat_addr_o, .beat_valid_o, .beat_last_o, .req_err_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] s, int len, int size, int bt, int i);
    logic [31:0] nb, al, win, base;
    nb = 32'd1 << size;
    al = s - (s % nb);
    win = nb * (len + 1);
    base = s - (s % win);
    case (bt)
      0: return s;
      1: return (i == 0) ? s : al + i * nb;
      default: return base + ((s - base + i * nb) % win);
    endcase
  endfunction

  // called and returns at a falling edge
  task automatic drive_req(logic [31:0] a, int len, int size, int bt);
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = 8'(len);
    req_size_i = 3'(size); req_burst_i = 2'(bt);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic run_burst(logic [31:0] s, int len, int size, int bt, string tag);
    for (int i = 0; i <= len; i++) begin
      chk({tag, " valid"}, 32'(beat_valid_o), 32'd1);
      chk({tag, " addr"}, beat_addr_o, exp_addr(s, len, size, bt, i));
      chk("R7 last", 32'(beat_last_o), 32'(i == len));
      beat_adv_i = 1'b1;
      @(negedge clk_i);
    end
    beat_adv_i = 1'b0;
    chk("R7 idle after last", 32'(beat_valid_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(beat_valid_o), 32'd0);
    chk("R1 last", 32'(beat_last_o), 32'd0);
    chk("R1 err", 32'(req_err_o), 32'd0);
  endtask

  task automatic t_incr;
    drive_req(32'h100, 3, 2, 1);
    chk("R2 start", beat_addr_o, 32'h100);
    run_burst(32'h100, 3, 2, 1, "R5 aligned");
    drive_req(32'h1002, 3, 2, 1);
    run_burst(32'h1002, 3, 2, 1, "R5 unaligned");
    drive_req(32'h20, 255, 0, 1);
    run_burst(32'h20, 255, 0, 1, "R5 long");
  endtask

  task automatic t_fixed;
    drive_req(32'h43, 15, 3, 0);
    run_burst(32'h43, 15, 3, 0, "R4 fixed");
  endtask

  task automatic t_wrap;
    drive_req(32'h38, 3, 2, 2);
    run_burst(32'h38, 3, 2, 2, "R6 wrap4");
    drive_req(32'h1048, 15, 3, 2);
    run_burst(32'h1048, 15, 3, 2, "R6 wrap16");
    drive_req(32'h7e, 1, 1, 2);
    run_burst(32'h7e, 1, 1, 2, "R6 wrap2");
  endtask

  task automatic t_hold;
    drive_req(32'h600, 1, 2, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R3 hold addr", beat_addr_o, 32'h600);
      chk("R3 hold valid", 32'(beat_valid_o), 32'd1);
      @(negedge clk_i);
    end
    run_burst(32'h600, 1, 2, 1, "R3 resume");
  endtask

  task automatic t_ignore;
    drive_req(32'h200, 3, 2, 1);
    drive_req(32'h900, 0, 0, 0);
    chk("R9 addr kept", beat_addr_o, 32'h200);
    chk("R9 no err", 32'(req_err_o), 32'd0);
    run_burst(32'h200, 3, 2, 1, "R9 continue");
  endtask

  task automatic err_case(logic [31:0] a, int len, int size, int bt, string tag);
    drive_req(a, len, size, bt);
    chk({tag, " err"}, 32'(req_err_o), 32'd1);
    chk({tag, " no burst"}, 32'(beat_valid_o), 32'd0);
    @(negedge clk_i);
    chk({tag, " pulse"}, 32'(req_err_o), 32'd0);
  endtask

  task automatic t_err;
    err_case(32'h0, 0, 0, 3, "R8 reserved");
    err_case(32'h0, 2, 2, 2, "R8 wrap len");
    err_case(32'h2, 3, 2, 2, "R8 wrap align");
    err_case(32'h0, 16, 0, 0, "R8 fixed len");
    err_case(32'h0, 0, 4, 1, "R8 size");
  endtask

  task automatic t_b2b;
    drive_req(32'h300, 1, 2, 1);
    chk("R10 first", beat_addr_o, 32'h300);
    beat_adv_i = 1'b1;
    @(negedge clk_i);
    chk("R10 last beat", 32'(beat_last_o), 32'd1);
    req_valid_i = 1'b1; req_addr_i = 32'h500; req_len_i = 8'd0;
    req_size_i = 3'd0; req_burst_i = 2'd1;
    @(negedge clk_i);
    req_valid_i = 1'b0; beat_adv_i = 1'b0;
    chk("R10 no gap", 32'(beat_valid_o), 32'd1);
    chk("R10 new addr", beat_addr_o, 32'h500);
    chk("R10 new last", 32'(beat_last_o), 32'd1);
    beat_adv_i = 1'b1;
    req_valid_i = 1'b1; req_burst_i = 2'd3;
    @(negedge clk_i);
    req_valid_i = 1'b0; beat_adv_i = 1'b0;
    chk("R10 bad b2b valid", 32'(beat_valid_o), 32'd0);
    chk("R8 bad b2b err", 32'(req_err_o), 32'd1);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_incr();
    t_fixed();
    t_wrap();
    t_hold();
    t_ignore();
    t_err();
    t_b2b();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule